// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block enciphers one 128-bit block at a time under AES with a 128-bit key. It uses one round datapath and runs it once per clock. The key schedule is not derived on chip. Software, or a neighbouring block, writes all 44 expanded-key words into an internal word store through a simple word-wide write port before any block is sent. The store then keeps those words for as many blocks as needed.

A plaintext block enters through a valid/ready input. When `in_valid` and `in_ready` are both high on a rising edge, the block is accepted, and the first key addition is applied at that same edge. The ten rounds then follow, one per clock. There is no input queue. `in_ready` is the only back-pressure on the input, and it stays low while a block is in flight. The result side has no back-pressure. `out_valid` is a one-cycle pulse, and `out_data` keeps the last ciphertext until the next one replaces it. A consumer that misses the pulse can still read the value afterwards.

Top module: `aes128_iter`

## Requirements
- R1: While reset is asserted and right after it is released, `in_ready` is 1, `out_valid` is 0 and `out_data` is all zeros.
- R2: A block is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle on, `in_ready` stays 0 until the cycle in which `out_valid` is 1.
- R3: `out_valid` is high for exactly one cycle. That cycle is the 11th cycle when the accepting cycle is counted as the first.
- R4: `out_data` changes only in a cycle where `out_valid` is 1. Otherwise it holds its previous value, including while the next block is being processed.
- R5: The result is the AES-128 encryption of the accepted block. The block is first XORed with round key 0. Rounds 1 to 9 then each apply byte substitution, row rotation, column mixing and key XOR. Round 10 leaves out the column mixing.
- R6: Byte order: byte k of a block is bits [127-8k -: 8]. It sits in state row k mod 4 and column k div 4. Row r is rotated left by r byte positions. Round n uses key words 4n to 4n+3. Word 4n+j forms column j, and its bits [31:24] are row 0.
- R7: When `key_we` is 1 on a rising edge in a cycle where `in_ready` is 1, `key_wdata` is stored at word `key_addr`, for addresses 0 to 43. Writes to addresses 44 to 63 change nothing.
- R8: Key writes made while a block is in flight (`in_ready` = 0) are dropped. Neither that block nor any later block sees them.
- R9: `in_valid` pulses while a block is in flight are ignored and do not alter the block being processed.
- R10: A new block may be accepted in the same cycle that `out_valid` is 1. It then completes with the same 11-cycle timing.
- R11: The stored key words persist across blocks. Several blocks can be enciphered after a single key load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Plaintext block offered |
| in_ready | output | 1 | Core is idle and can take a block |
| in_data | input | 128 | Plaintext block, byte 0 in the top bits |
| out_valid | output | 1 | One-cycle pulse when a ciphertext is ready |
| out_data | output | 128 | Most recent ciphertext |
| key_we | input | 1 | Expanded-key word write enable |
| key_addr | input | 6 | Expanded-key word address |
| key_wdata | input | 32 | Expanded-key word data |

## Verification
The bench builds the core with its default parameters: ten rounds and a 6-bit key-word address. With these values the whole 44-word store is reachable, and so are the 20 unused addresses above it, which must have no effect. Three published AES-128 vectors are run: the standard example with an ascending key, the worked-example key, and an all-zero key and block. Between them they cover the byte and word ordering and the reduced final round. Each vector's round keys are expanded inside the bench. Directed cases then check the done-cycle re-accept, the dropped mid-block key writes and the ignored mid-block `in_valid`.

// File: rtl/aes128_pkg.sv
package aes128_pkg;

  localparam int unsigned BLK_BITS  = 128;
  localparam int unsigned BLK_BYTES = BLK_BITS / 8;
  localparam int unsigned ST_ROWS   = 4;
  localparam int unsigned WORD_BITS = 32;

  typedef logic [7:0] gf8_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic gf8_t gf_dbl(gf8_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // general GF(2^8) product, shift-and-add
  function automatic gf8_t gf_mul(gf8_t a, gf8_t b);
    gf8_t acc;
    gf8_t sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes128_pkg::*;
(
  input  gf8_t din,
  output gf8_t dout
);

  gf8_t p2, p3, p6, p12, p15, p30, p60, p120, p240, p252, inv;
  gf8_t rl1, rl2, rl3, rl4;

  // inverse as din^254 (zero maps to zero), addition chain
  always_comb begin
    p2   = gf_mul(din, din);
    p3   = gf_mul(p2, din);
    p6   = gf_mul(p3, p3);
    p12  = gf_mul(p6, p6);
    p15  = gf_mul(p12, p3);
    p30  = gf_mul(p15, p15);
    p60  = gf_mul(p30, p30);
    p120 = gf_mul(p60, p60);
    p240 = gf_mul(p120, p120);
    p252 = gf_mul(p240, p12);
    inv  = gf_mul(p252, p2);
  end

  // affine step: xor of four left rotations and the constant 0x63
  always_comb begin
    rl1  = {inv[6:0], inv[7]};
    rl2  = {inv[5:0], inv[7:6]};
    rl3  = {inv[4:0], inv[7:5]};
    rl4  = {inv[3:0], inv[7:4]};
    dout = inv ^ rl1 ^ rl2 ^ rl3 ^ rl4 ^ 8'h63;
  end

endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes128_pkg::*;
(
  input  logic [BLK_BITS-1:0] st_in,
  input  logic [BLK_BITS-1:0] rkey,
  input  logic                last,
  output logic [BLK_BITS-1:0] st_out
);

  gf8_t sub_b [BLK_BYTES];
  gf8_t shf_b [BLK_BYTES];
  gf8_t mix_b [BLK_BYTES];

  genvar k, c, r;

  // byte substitution, one table per byte
  generate
    for (k = 0; k < BLK_BYTES; k++) begin : g_sub
      aes_sbox u_sbox (
        .din  (st_in[BLK_BITS-1-8*k -: 8]),
        .dout (sub_b[k])
      );
    end
  endgenerate

  // row r rotated left by r: byte (c,r) takes (c+r mod 4, r)
  generate
    for (c = 0; c < ST_ROWS; c++) begin : g_shc
      for (r = 0; r < ST_ROWS; r++) begin : g_shr
        assign shf_b[ST_ROWS*c+r] = sub_b[ST_ROWS*((c+r)%ST_ROWS)+r];
      end
    end
  endgenerate

  // column mixing with coefficients {02,03,01,01} rotated per row
  generate
    for (c = 0; c < ST_ROWS; c++) begin : g_mix
      gf8_t a0, a1, a2, a3;
      assign a0 = shf_b[ST_ROWS*c+0];
      assign a1 = shf_b[ST_ROWS*c+1];
      assign a2 = shf_b[ST_ROWS*c+2];
      assign a3 = shf_b[ST_ROWS*c+3];
      assign mix_b[ST_ROWS*c+0] = gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3;
      assign mix_b[ST_ROWS*c+1] = a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3;
      assign mix_b[ST_ROWS*c+2] = a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3;
      assign mix_b[ST_ROWS*c+3] = gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3);
    end
  endgenerate

  // key addition; the final round bypasses the mixing
  generate
    for (k = 0; k < BLK_BYTES; k++) begin : g_ark
      assign st_out[BLK_BITS-1-8*k -: 8] =
        (last ? shf_b[k] : mix_b[k]) ^ rkey[BLK_BITS-1-8*k -: 8];
    end
  endgenerate

endmodule

// File: rtl/aes_keyfile.sv
module aes_keyfile
  import aes128_pkg::*;
#(
  parameter int unsigned NWORDS = 44,
  parameter int unsigned AW     = 6,
  parameter int unsigned RW     = 4
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [WORD_BITS-1:0] wdata,
  input  logic [RW-1:0]        rsel,
  output logic [BLK_BITS-1:0]  rkey
);

  localparam int unsigned NRKEYS = NWORDS / ST_ROWS;

  logic [WORD_BITS-1:0] words  [NWORDS];
  logic [BLK_BITS-1:0]  rk_tab [NRKEYS];

  genvar i, n;

  generate
    for (i = 0; i < NWORDS; i++) begin : g_word
      logic [WORD_BITS-1:0] w_q;
      always_ff @(posedge clk) begin
        if (we && (waddr == AW'(i))) w_q <= wdata;
      end
      assign words[i] = w_q;
    end
  endgenerate

  // group four consecutive words into one round key, word 4n on top
  generate
    for (n = 0; n < NRKEYS; n++) begin : g_rk
      assign rk_tab[n] = {words[ST_ROWS*n+0], words[ST_ROWS*n+1],
                          words[ST_ROWS*n+2], words[ST_ROWS*n+3]};
    end
  endgenerate

  assign rkey = rk_tab[rsel];

endmodule

// File: rtl/aes_ctrl.sv
module aes_ctrl
  import aes128_pkg::*;
#(
  parameter int unsigned NR = 10,
  parameter int unsigned RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          accept,
  output logic          busy,
  output logic          last,
  output logic [RW-1:0] rnd,
  output logic          done
);

  seq_state_e    st_q;
  logic [RW-1:0] rnd_q;
  logic          done_q;

  assign in_ready = (st_q == SEQ_IDLE);
  assign busy     = (st_q == SEQ_RUN);
  assign accept   = in_valid && in_ready;
  assign last     = (rnd_q == RW'(NR));
  assign rnd      = rnd_q;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      rnd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy && last;
      unique case (st_q)
        SEQ_IDLE: begin
          if (accept) begin
            st_q  <= SEQ_RUN;
            rnd_q <= RW'(1);
          end
        end
        SEQ_RUN: begin
          if (last) begin
            st_q  <= SEQ_IDLE;
            rnd_q <= '0;
          end else begin
            rnd_q <= rnd_q + RW'(1);
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/aes128_iter.sv
module aes128_iter
  import aes128_pkg::*;
#(
  parameter int unsigned NR  = 10,
  parameter int unsigned KAW = $clog2(4 * (NR + 1))
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [127:0]   in_data,
  output logic           out_valid,
  output logic [127:0]   out_data,
  input  logic           key_we,
  input  logic [KAW-1:0] key_addr,
  input  logic [31:0]    key_wdata
);

  localparam int unsigned NWORDS = ST_ROWS * (NR + 1);
  localparam int unsigned RW     = $clog2(NR + 1);

  logic                accept, busy, last;
  logic [RW-1:0]       rnd;
  logic [BLK_BITS-1:0] rkey, rnd_out;
  logic [BLK_BITS-1:0] st_q, ct_q;

  aes_ctrl #(.NR(NR), .RW(RW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .busy     (busy),
    .last     (last),
    .rnd      (rnd),
    .done     (out_valid)
  );

  // writes are only taken while idle
  aes_keyfile #(.NWORDS(NWORDS), .AW(KAW), .RW(RW)) u_keys (
    .clk   (clk),
    .we    (key_we && !busy),
    .waddr (key_addr),
    .wdata (key_wdata),
    .rsel  (rnd),
    .rkey  (rkey)
  );

  aes_round u_round (
    .st_in  (st_q),
    .rkey   (rkey),
    .last   (last),
    .st_out (rnd_out)
  );

  // initial key addition at accept (round index 0 while idle),
  // then one round per cycle; result captured on the final round
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      ct_q <= '0;
    end else begin
      if (accept)    st_q <= in_data ^ rkey;
      else if (busy) st_q <= rnd_out;
      if (busy && last) ct_q <= rnd_out;
    end
  end

  assign out_data = ct_q;

endmodule

// File: rtl/aes128_iter_chk.sv
module aes128_iter_chk #(
  parameter int unsigned NR = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic [127:0] out_data
);

  localparam int unsigned CW = $clog2(NR + 2) + 1;

  // cycles since the accepting edge; NR+1 in the result cycle
  logic [CW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      age_q <= '0;
    else if (in_valid && in_ready)   age_q <= CW'(1);
    else if (out_valid)              age_q <= '0;
    else if (age_q != '0)            age_q <= age_q + CW'(1);
  end

  p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != '0 && age_q <= CW'(NR)) |-> !in_ready);

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (age_q == CW'(NR + 1)));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  p_ready_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

endmodule

bind aes128_iter aes128_iter_chk #(.NR(NR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_aes128_iter.sv
`timescale 1ns/1ps
module test_aes128_iter;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic [127:0] out_data;
  logic         key_we = 1'b0;
  logic [5:0]   key_addr = '0;
  logic [31:0]  key_wdata = '0;

  int n_total = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  aes128_iter i_aes128_iter (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .key_we(key_we), .key_addr(key_addr), .key_wdata(key_wdata)
  );

  // {key, plaintext, ciphertext}
  localparam logic [383:0] VEC [3] = '{
    {128'h000102030405060708090a0b0c0d0e0f,
     128'h00112233445566778899aabbccddeeff,
     128'h69c4e0d86a7b0430d8cdb78070b4c55a},
    {128'h2b7e151628aed2a6abf7158809cf4f3c,
     128'h3243f6a8885a308d313198a2e0370734,
     128'h3925841d02dc09fbdc118597196a0b32},
    {128'h0, 128'h0,
     128'h66e94bd4ef8a2c3b884cfa59ca342b2e}
  };

  logic [31:0] ek [44];

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'h11b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] ref_sbox(logic [7:0] b);
    logic [7:0] inv, o;
    inv = 8'h00;
    for (int y = 1; y < 256; y++)
      if (ref_mul(b, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
             ^ inv[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
    return o;
  endfunction

  task automatic expand(input logic [127:0] key);
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) ek[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = ek[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {ref_sbox(t[31:24]), ref_sbox(t[23:16]),
             ref_sbox(t[15:8]), ref_sbox(t[7:0])} ^ {rc, 24'h0};
        rc = ref_mul(rc, 8'h02);
      end
      ek[i] = ek[i-4] ^ t;
    end
  endtask

  // R7: all 64 addresses written; 44..63 get junk that must not matter
  task automatic load_key(input logic [127:0] key);
    expand(key);
    for (int i = 0; i < 64; i++) begin
      key_we    = 1'b1;
      key_addr  = 6'(i);
      key_wdata = (i < 44) ? ek[i] : (32'hdeadbeef ^ 32'(i));
      @(negedge clk);
    end
    key_we = 1'b0;
  endtask

  // called at a negedge; mode 1: key write mid-block, mode 2: in_valid mid-block
  task automatic run_block(input logic [127:0] pt, input int mode,
                           output logic [127:0] ct, output int lat);
    bit busy_ok;
    bit hold_ok;
    logic [127:0] prev;
    prev     = out_data;
    in_valid = 1'b1;
    in_data  = pt;
    check(in_ready === 1'b1, "R2 ready before accept", 128'(in_ready), 128'd1);
    @(negedge clk);
    in_valid = 1'b0;
    lat      = 1;
    busy_ok  = 1'b1;
    hold_ok  = 1'b1;
    while (out_valid !== 1'b1 && lat < 40) begin
      if (in_ready !== 1'b0) busy_ok = 1'b0;
      if (out_data !== prev) hold_ok = 1'b0;
      if (lat == 3 && mode == 1) begin
        key_we = 1'b1; key_addr = 6'd0; key_wdata = 32'hffffffff;
      end
      if (lat == 3 && mode == 2) begin
        in_valid = 1'b1; in_data = ~pt;
      end
      @(negedge clk);
      key_we   = 1'b0;
      in_valid = 1'b0;
      lat++;
    end
    check(busy_ok, "R2 ready low while busy", 128'(busy_ok), 128'd1);
    check(hold_ok, "R4 output held while busy", 128'(hold_ok), 128'd1);
    ct = out_data;
  endtask

  initial begin
    #2000000;
    n_fail++;
    n_total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    logic [127:0] ct, ct2, exp_ct;
    int lat;

    repeat (3) @(negedge clk);
    // R1 during reset
    check(in_ready === 1'b1, "R1 ready in reset", 128'(in_ready), 128'd1);
    check(out_valid === 1'b0, "R1 valid in reset", 128'(out_valid), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_data === '0, "R1 data after reset", out_data, 128'd0);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R1 handshake after reset",
          {in_ready, out_valid}, 128'b10);

    // vector table: R5, R6 (byte/word order), R3 timing, R4 hold
    for (int v = 0; v < 3; v++) begin
      load_key(VEC[v][383:256]);
      run_block(VEC[v][255:128], 0, ct, lat);
      check(ct === VEC[v][127:0], "R5 R6 R7 ciphertext", ct, VEC[v][127:0]);
      check(lat == 11, "R3 latency", 128'(lat), 128'd11);
      @(negedge clk);
      check(out_valid === 1'b0, "R3 single pulse", 128'(out_valid), 128'd0);
      repeat (3) @(negedge clk);
      check(out_data === VEC[v][127:0] && out_valid === 1'b0, "R4 result held",
            out_data, VEC[v][127:0]);
    end

    // R10: back-to-back, second block accepted in the result cycle
    exp_ct = VEC[2][127:0];
    run_block(VEC[2][255:128], 0, ct, lat);
    run_block(VEC[2][255:128], 0, ct2, lat);
    check(ct2 === exp_ct, "R10 back-to-back result", ct2, exp_ct);
    check(lat == 11, "R10 back-to-back latency", 128'(lat), 128'd11);
    @(negedge clk);

    // R8: key write during a block is dropped
    load_key(VEC[0][383:256]);
    exp_ct = VEC[0][127:0];
    run_block(VEC[0][255:128], 1, ct, lat);
    check(ct === exp_ct, "R8 busy write, same block", ct, exp_ct);
    @(negedge clk);
    run_block(VEC[0][255:128], 0, ct, lat);
    check(ct === exp_ct, "R8 R11 busy write, later block", ct, exp_ct);
    @(negedge clk);

    // R9: in_valid while busy is ignored
    run_block(VEC[0][255:128], 2, ct, lat);
    check(ct === exp_ct, "R9 in_valid while busy", ct, exp_ct);
    check(lat == 11, "R9 latency unchanged", 128'(lat), 128'd11);
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R9 no extra block",
          {out_valid, in_ready}, 128'b01);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule